// File: doc/BRIEF.md
# UART Receive Status and Flow-Control Controller

This block sits between a UART receiver's deserializer and the software-visible receive side. It keeps a small receive FIFO of characters, each stored with its break, framing-error and parity-error flags. It reports the error status either for the character at the head of the FIFO or as a sticky accumulation. It picks whether the interrupt/DMA request follows "data available" or "FIFO full". It also drives a receiver flow-control output that tells the far transmitter to pause.

Two mode registers share one bus address. An internal pointer picks the first register after reset. Any access to the first register moves the pointer on to the second, and a command code sends it back. The first mode register holds, from the top bit down: receiver flow-control enable (bit 7), request source select (bit 6), error reporting mode (bit 5), parity mode (bits 4:3), parity type (bit 2) and character length (bits 1:0). The parity and length fields are stored for the deserializer and are not used here. In the second mode register, bit 4 is the transmitter flow-control enable.

Top module: `uart_rxs_ctl`

## Requirements
- R1: After reset, both mode registers read 0 and the pointer selects register 1. The FIFO is empty, all status outputs are 0, `overrun` is 0 and `rts_o` is 1.
- R2: A read or write while the pointer selects register 1 moves the pointer to register 2, and later accesses stay on register 2. A write stores into the selected register, and `reg_rdata` always shows the selected register.
- R3: A `cmd_wr` with `cmd_misc` = 3'd1 returns the pointer to register 1. This takes priority over an access made in the same cycle.
- R4: With register 1 bit 7 = 1 and register 2 bit 4 = 0, a `start_det` while the FIFO is full drives `rts_o` low from the next cycle.
- R5: Once negated, `rts_o` returns to 1 in the same cycle that the FIFO holds fewer than DEPTH entries.
- R6: With register 1 bit 7 = 0, `rts_o` stays 1 whatever the FIFO and `start_det` do.
- R7: With register 1 bit 7 = 1 and register 2 bit 4 = 1, flow control is disabled and `rts_o` stays 1.
- R8: `rx_req` equals `rx_ready` (FIFO not empty) when register 1 bit 6 = 0, and equals `rx_full` when it is 1.
- R9: In character mode (register 1 bit 5 = 0), `stat_brk`, `stat_fe` and `stat_pe` show the flags of the head character, and read 0 when the FIFO is empty.
- R10: In block mode (bit 5 = 1), each status bit is the OR of that flag over every character that has become the FIFO head since the last `cmd_misc` = 3'd2 command. A character that becomes head in the clear cycle is counted after the clear.
- R11: The FIFO holds DEPTH (default 4) characters in arrival order, and `fifo_pop` removes the head. A `char_done` while the FIFO is full drops the character and sets `overrun`, and command 3'd2 clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe to the shared mode-register address |
| reg_rd | input | 1 | Read strobe to the shared mode-register address |
| reg_wdata | input | 8 | Write data for the selected mode register |
| reg_rdata | output | 8 | Contents of the selected mode register |
| cmd_wr | input | 1 | Command strobe |
| cmd_misc | input | 3 | Command code: 1 = pointer home, 2 = clear error status |
| start_det | input | 1 | Valid start bit seen by the deserializer |
| char_done | input | 1 | Complete character available |
| char_data | input | 8 | Received character |
| char_brk | input | 1 | Break flag of the character |
| char_fe | input | 1 | Framing-error flag of the character |
| char_pe | input | 1 | Parity-error flag of the character |
| fifo_pop | input | 1 | Remove the head character |
| rx_data | output | 8 | Head character |
| rx_ready | output | 1 | FIFO not empty |
| rx_full | output | 1 | FIFO full |
| rx_req | output | 1 | Interrupt/DMA request |
| rts_o | output | 1 | Receiver flow control, 1 = may send |
| stat_brk | output | 1 | Break status |
| stat_fe | output | 1 | Framing-error status |
| stat_pe | output | 1 | Parity-error status |
| overrun | output | 1 | A character was dropped because the FIFO was full |

## Verification
The bench builds the block with its default values: a FIFO depth of 4 and an 8-bit character. With only four entries, four pushes reach the full state. That brings the flow-control negation, its reassertion on the first pop and the overrun drop within a few cycles of each other. It also lets the bench drain the FIFO while in block mode, which shows the sticky status surviving after the flagged character has left.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
   // status flag positions inside a 3-bit flag vector
   localparam int FLG_BRK = 2;
   localparam int FLG_FE  = 1;
   localparam int FLG_PE  = 0;
   localparam int FLG_W   = 3;

   // mode register 1 fields
   localparam int MR1_FLOW   = 7;
   localparam int MR1_REQSEL = 6;
   localparam int MR1_BLOCK  = 5;
   // mode register 2 fields
   localparam int MR2_TXFLOW = 4;

   // command codes
   localparam int          CMD_W       = 3;
   localparam logic [2:0]  CMD_PTR_HOME = 3'd1;
   localparam logic [2:0]  CMD_ERR_CLR  = 3'd2;
endpackage

// File: rtl/uart_rxs_modereg.sv
module uart_rxs_modereg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_wr,
   input  logic             acc_rd,
   input  logic [REG_W-1:0] wdata,
   input  logic             ptr_home,
   output logic [REG_W-1:0] rdata,
   output logic [REG_W-1:0] mr1,
   output logic [REG_W-1:0] mr2
);
   if (REG_W < 8) begin : g_bad_w
      $error("mode register must be at least 8 bits");
   end

   logic sel2_q;   // 0 selects register 1

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel2_q <= 1'b0;
         mr1    <= '0;
         mr2    <= '0;
      end else begin
         if (acc_wr) begin
            if (sel2_q) mr2 <= wdata;
            else        mr1 <= wdata;
         end
         if (ptr_home)                           sel2_q <= 1'b0;
         else if ((acc_wr || acc_rd) && !sel2_q) sel2_q <= 1'b1;
      end
   end

   assign rdata = sel2_q ? mr2 : mr1;

   a_r2_ptr_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel2_q && (acc_wr || acc_rd) && !ptr_home) |=> sel2_q);
   a_r3_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_home |=> !sel2_q);
   a_r2_mr1_kept: assert property (@(posedge clk) disable iff (!rst_n)
      sel2_q |=> $stable(mr1));
endmodule

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo
   import uart_rxs_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [FLG_W-1:0]  push_flags,
   input  logic              pop,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] head_data,
   output logic [FLG_W-1:0]  head_flags,
   output logic              empty,
   output logic              full,
   output logic              pop_ok,
   output logic              overrun
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [FLG_W-1:0]  mem_f [DEPTH];
   logic [PTR_W-1:0]  wr_q, rd_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              push_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_ok && wr_q == PTR_W'(i)) begin
            mem_d[i] <= push_data;
            mem_f[i] <= push_flags;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         cnt_q   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (pop_ok)  rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
         if (push && full) overrun <= 1'b1;
         else if (ovr_clr) overrun <= 1'b0;
      end
   end

   assign head_data  = mem_d[rd_q];
   assign head_flags = mem_f[rd_q];

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   a_r11_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> overrun);
   a_r11_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/uart_rxs_errstat.sv
module uart_rxs_errstat
   import uart_rxs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLG_W-1:0] head_flags,
   input  logic             head_valid,
   input  logic             pop_ok,
   input  logic             clr,
   input  logic             block_mode,
   output logic [FLG_W-1:0] stat
);
   logic [FLG_W-1:0] acc_q;
   logic             seen_q;   // head flags already folded into acc_q
   logic [FLG_W-1:0] fresh;

   assign fresh = (head_valid && !seen_q) ? head_flags : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         acc_q  <= (clr ? '0 : acc_q) | fresh;
         seen_q <= pop_ok ? 1'b0 : (seen_q | head_valid);
      end
   end

   assign stat = block_mode ? (acc_q | fresh)
                            : (head_valid ? head_flags : '0);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
   a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !head_valid) |=> (acc_q == '0));
endmodule

// File: rtl/uart_rxs_flow.sv
module uart_rxs_flow (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start_det,
   input  logic full,
   output logic rts_o
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 hold_q <= 1'b0;
      else if (!en)               hold_q <= 1'b0;
      else if (start_det && full) hold_q <= 1'b1;
      else if (!full)             hold_q <= 1'b0;
   end

   assign rts_o = !(en && hold_q && full);

   a_r4_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
      (en && start_det && full) |=> hold_q);
   a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !hold_q);
endmodule

// File: rtl/uart_rxs_ctl.sv
module uart_rxs_ctl
   import uart_rxs_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_misc,
   input  logic              start_det,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_brk,
   input  logic              char_fe,
   input  logic              char_pe,
   input  logic              fifo_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              rx_full,
   output logic              rx_req,
   output logic              rts_o,
   output logic              stat_brk,
   output logic              stat_fe,
   output logic              stat_pe,
   output logic              overrun
);
   logic [7:0]       mr1, mr2;
   logic             ptr_home, err_clr, empty, pop_ok, flow_en;
   logic [FLG_W-1:0] in_flags, head_flags, stat;

   assign ptr_home = cmd_wr && (cmd_misc == CMD_PTR_HOME);
   assign err_clr  = cmd_wr && (cmd_misc == CMD_ERR_CLR);

   assign in_flags[FLG_BRK] = char_brk;
   assign in_flags[FLG_FE]  = char_fe;
   assign in_flags[FLG_PE]  = char_pe;

   uart_rxs_modereg #(.REG_W(8)) u_mode (
      .clk(clk), .rst_n(rst_n), .acc_wr(reg_wr), .acc_rd(reg_rd),
      .wdata(reg_wdata), .ptr_home(ptr_home), .rdata(reg_rdata),
      .mr1(mr1), .mr2(mr2));

   uart_rxs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(char_done), .push_data(char_data),
      .push_flags(in_flags), .pop(fifo_pop), .ovr_clr(err_clr),
      .head_data(rx_data), .head_flags(head_flags), .empty(empty),
      .full(rx_full), .pop_ok(pop_ok), .overrun(overrun));

   uart_rxs_errstat u_err (
      .clk(clk), .rst_n(rst_n), .head_flags(head_flags), .head_valid(!empty),
      .pop_ok(pop_ok), .clr(err_clr), .block_mode(mr1[MR1_BLOCK]),
      .stat(stat));

   // both sides asking for flow control cancels it
   assign flow_en = mr1[MR1_FLOW] && !mr2[MR2_TXFLOW];

   uart_rxs_flow u_flow (
      .clk(clk), .rst_n(rst_n), .en(flow_en), .start_det(start_det),
      .full(rx_full), .rts_o(rts_o));

   assign rx_ready = !empty;
   assign rx_req   = mr1[MR1_REQSEL] ? rx_full : !empty;
   assign stat_brk = stat[FLG_BRK];
   assign stat_fe  = stat[FLG_FE];
   assign stat_pe  = stat[FLG_PE];

   a_r5_rts_back: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_full |-> rts_o);
   a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !mr1[MR1_BLOCK]) |-> (stat == '0));
endmodule

// File: tb/tb_uart_rxs_ctl.sv
module tb_uart_rxs_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 0, reg_rd = 0, cmd_wr = 0;
   logic [7:0] reg_wdata = 0, reg_rdata;
   logic [2:0] cmd_misc = 0;
   logic       start_det = 0, char_done = 0, char_brk = 0, char_fe = 0, char_pe = 0;
   logic [7:0] char_data = 0, rx_data;
   logic       fifo_pop = 0;
   logic       rx_ready, rx_full, rx_req, rts_o, stat_brk, stat_fe, stat_pe, overrun;

   int total = 0, bad = 0;
   logic [7:0] q[$];

   always #4 clk = ~clk;   // 125 MHz

   uart_rxs_ctl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
      .cmd_misc(cmd_misc), .start_det(start_det), .char_done(char_done),
      .char_data(char_data), .char_brk(char_brk), .char_fe(char_fe),
      .char_pe(char_pe), .fifo_pop(fifo_pop), .rx_data(rx_data),
      .rx_ready(rx_ready), .rx_full(rx_full), .rx_req(rx_req), .rts_o(rts_o),
      .stat_brk(stat_brk), .stat_fe(stat_fe), .stat_pe(stat_pe),
      .overrun(overrun));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic stat_is(input string req, input int exp);
      chk(req, {stat_brk, stat_fe, stat_pe}, exp);
   endtask

   // driver tasks: one cycle each, checks follow at negedge + 1
   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk); reg_wr = 1; reg_wdata = v;
      @(negedge clk); reg_wr = 0; #1;
   endtask

   task automatic cmd(input logic [2:0] c, input bit with_rd);
      @(negedge clk); cmd_wr = 1; cmd_misc = c; reg_rd = with_rd;
      @(negedge clk); cmd_wr = 0; reg_rd = 0; #1;
   endtask

   task automatic push(input logic [7:0] d, input bit b, input bit f, input bit p);
      @(negedge clk);
      char_done = 1; char_data = d; char_brk = b; char_fe = f; char_pe = p;
      if (q.size() < 4) q.push_back(d);
      @(negedge clk); char_done = 0; #1;
   endtask

   task automatic start();
      @(negedge clk); start_det = 1;
      @(negedge clk); start_det = 0; #1;
   endtask

   task automatic pop();
      @(negedge clk); fifo_pop = 1;
      @(negedge clk); fifo_pop = 0; #1;
   endtask

   // monitor: compares the head against the scoreboard on every pop
   always begin
      @(negedge clk); #1;
      if (fifo_pop === 1'b1) begin
         if (q.size() == 0) chk("R11 pop with empty model", 1, 0);
         else chk("R11 arrival order", rx_data, q.pop_front());
      end
   end

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk("R1 mode reg", reg_rdata, 0);
      chk("R1 ready", rx_ready, 0);
      chk("R1 rts", rts_o, 1);
      stat_is("R1 status", 0);
      chk("R1 overrun", overrun, 0);

      wr_reg(8'h80);  chk("R2 pointer on reg2", reg_rdata, 8'h00);
      wr_reg(8'h4A);  chk("R2 stays on reg2", reg_rdata, 8'h4A);
      cmd(3'd1, 0);   chk("R3 pointer home", reg_rdata, 8'h80);
      cmd(3'd1, 1);   chk("R3 home beats read", reg_rdata, 8'h80);

      push(8'hA0, 0, 1, 0);
      chk("R8 req from ready", rx_req, 1);
      stat_is("R9 head flags", 3'b010);
      push(8'hA1, 0, 0, 1);
      push(8'hA2, 1, 0, 0);
      push(8'hA3, 0, 0, 0);
      chk("R11 full", rx_full, 1);
      stat_is("R9 head unchanged", 3'b010);
      chk("R4 rts before start", rts_o, 1);
      start();        chk("R4 rts negated", rts_o, 0);
      push(8'hB4, 1, 1, 1);
      chk("R11 overrun", overrun, 1);
      pop();
      chk("R5 rts reasserted", rts_o, 1);
      stat_is("R9 next head", 3'b001);

      cmd(3'd1, 0); wr_reg(8'hC0);
      chk("R8 req from full, not full", rx_req, 0);
      push(8'hA4, 0, 0, 0);
      chk("R8 req from full, full", rx_req, 1);

      cmd(3'd1, 0); wr_reg(8'hA0);
      cmd(3'd2, 0);
      stat_is("R10 cleared", 0);
      chk("R11 overrun cleared", overrun, 0);
      pop();          stat_is("R10 new head counted", 3'b100);
      pop();          stat_is("R10 sticky", 3'b100);
      pop(); pop();
      chk("R11 drained", rx_ready, 0);
      stat_is("R10 sticky when empty", 3'b100);
      cmd(3'd1, 0); wr_reg(8'h00);
      stat_is("R9 empty shows zero", 0);

      push(8'hC0, 0, 0, 0); push(8'hC1, 0, 0, 0);
      push(8'hC2, 0, 0, 0); push(8'hC3, 0, 0, 0);
      start();        chk("R6 flow disabled", rts_o, 1);
      cmd(3'd1, 0); wr_reg(8'h80); wr_reg(8'h10);
      start();        chk("R7 both enabled cancels", rts_o, 1);
      wr_reg(8'h00);
      start();        chk("R4 rts negated again", rts_o, 0);
      pop();          chk("R5 rts back", rts_o, 1);
      pop(); pop(); pop();
      chk("R11 scoreboard empty", q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule